// File: doc/BRIEF.md
# Strided Tile Copy Engine

The block moves words from a large home memory into a fast local scratchpad while the processors that requested the copy go on running. A requester hands over a command that names a source word address, a destination word address and a word count. A linear command copies the words in order. A tile command also gives a row width and a row pitch. The engine reads each row from the source, skips the gap up to the next row, and packs all the rows one after another in the destination.

Every accepted command gets a 4-bit ticket in the cycle it is accepted. A command can ask to join the command before it, and then it reuses that command's ticket. A requester that needs the data names a ticket on the query input. The block reports the ticket as finished only when every copy holding that ticket has written its last word. Commands wait in a small queue, and the block refuses new ones only while that queue is full.

Top module: `tile_dma`

## Requirements
- R1: A linear command (tile flag 0) copies `len` words: home word `src+k` goes to scratch word `dst+k` for k from 0 to len-1. One home read is issued per cycle while a copy runs.
- R2: A tile command (tile flag 1) reads source word `src + (k / row)*pitch + (k % row)` for the k-th word and writes it to `dst+k`, so destination addresses only ever increase by one. A last row shorter than `row` is copied as far as `len` reaches. A row width of 0 makes a tile command behave like a linear one.
- R3: `cmd_id` shows the ticket that an accepted command receives, in the same cycle as `cmd_valid && cmd_ready`. Tickets for commands that do not join start at 0 after reset and go up by one per such command, modulo 16.
- R4: A command with the join flag set receives the ticket most recently handed out and does not advance the ticket sequence.
- R5: `wait_done` for the ticket on `wait_id` is 1 exactly when no copy holding that ticket is outstanding. It goes to 0 at the clock edge that accepts a non-empty command with that ticket. It goes back to 1 only at the edge that completes the last write of the last such copy.
- R6: Each scratch write comes exactly one cycle after the home read it carries. The written data is the word that read returned.
- R7: The command queue holds 4 commands. `cmd_ready` is 0 while it is full, and a refused command is not queued.
- R8: A command with `len` = 0 makes no memory access and leaves its ticket finished. It still uses up a ticket unless it joins.
- R9: After reset `cmd_ready` is 1, no read or write is issued, and every ticket reports finished.
- R10: Commands can be accepted while a copy is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command queue can take a command |
| cmd_2d | input | 1 | 1 = tile copy, 0 = linear copy |
| cmd_merge | input | 1 | Join the previous command's ticket |
| cmd_src | input | AW | Source word address in home memory |
| cmd_dst | input | AW | Destination word address in scratchpad |
| cmd_len | input | LW | Total words to copy |
| cmd_line | input | LW | Row width in words (tile copies) |
| cmd_stride | input | AW | Row pitch in words (tile copies) |
| cmd_id | output | IDW | Ticket given to the offered command |
| wait_id | input | IDW | Ticket being queried |
| wait_done | output | 1 | Queried ticket has nothing outstanding |
| src_rd_en | output | 1 | Home memory read strobe |
| src_addr | output | AW | Home memory read address |
| src_rdata | input | DW | Home read data, one cycle after the strobe |
| dst_wr_en | output | 1 | Scratch write strobe |
| dst_addr | output | AW | Scratch write address |
| dst_wdata | output | DW | Scratch write data |

## Verification
The ticket on `cmd_id` is combinational, so the bench samples it a moment after driving a command and before the accepting edge. `wait_done` drops right after that accepting edge. The first home read comes two edges after acceptance (queue write, then load into the engine), and each scratch write trails its read by exactly one edge. `wait_done` rises at the same edge that stores the last word, so the bench checks the scratch contents only once it sees the ticket finished. A monitor running on the falling edge compares every write with the read of the previous cycle. Refusal by the full queue is sampled on the sixth back-to-back command, after exactly four commands are waiting behind the one being copied.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_RUN  = 1'b1
   } eng_state_t;
endpackage

// File: rtl/tdma_cmd_fifo.sv
module tdma_cmd_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tdma_cmd_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  slot [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign dout  = slot[rp];

   always_ff @(posedge clk) begin
      if (push && !full) slot[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push && !full) wp <= wp + 1'b1;
         if (pop && !empty) rp <= rp + 1'b1;
         cnt <= cnt + CW'(push && !full) - CW'(pop && !empty);
      end
   end

   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> full);
endmodule

// File: rtl/tdma_addr_gen.sv
module tdma_addr_gen
   import tdma_pkg::*;
#(
   parameter int AW  = 10,
   parameter int LW  = 8,
   parameter int IDW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_avail,
   input  logic           c_2d,
   input  logic [AW-1:0]  c_src,
   input  logic [AW-1:0]  c_dst,
   input  logic [LW-1:0]  c_len,
   input  logic [LW-1:0]  c_line,
   input  logic [AW-1:0]  c_stride,
   input  logic [IDW-1:0] c_id,
   output logic           pop,
   output logic           rd_en,
   output logic [AW-1:0]  rd_addr,
   output logic [AW-1:0]  out_dst,
   output logic           out_last,
   output logic [IDW-1:0] out_id
);
   eng_state_t     st;
   logic [AW-1:0]  base, dst, pitch;
   logic [LW-1:0]  col, row, rem;
   logic [IDW-1:0] id;

   assign pop      = (st == ENG_IDLE) && cmd_avail;
   assign rd_en    = (st == ENG_RUN);
   assign rd_addr  = base + AW'(col);
   assign out_dst  = dst;
   assign out_last = (rem == LW'(1));
   assign out_id   = id;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ENG_IDLE;
         base  <= '0;
         dst   <= '0;
         pitch <= '0;
         col   <= '0;
         row   <= '0;
         rem   <= '0;
         id    <= '0;
      end else if (pop) begin
         if (c_len != '0) begin
            st    <= ENG_RUN;
            base  <= c_src;
            dst   <= c_dst;
            pitch <= c_stride;
            col   <= '0;
            row   <= (c_2d && c_line != '0) ? c_line : c_len;
            rem   <= c_len;
            id    <= c_id;
         end
      end else if (st == ENG_RUN) begin
         dst <= dst + 1'b1;
         rem <= rem - 1'b1;
         if (rem == LW'(1)) st <= ENG_IDLE;
         if (col == row - 1'b1) begin
            col  <= '0;
            base <= base + pitch;
         end else begin
            col <= col + 1'b1;
         end
      end
   end

   a_r2_col_in_row: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ENG_RUN) |-> (col < row));
   a_r1_rem_live: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ENG_RUN) |-> (rem != '0));
endmodule

// File: rtl/tdma_id_track.sv
module tdma_id_track #(
   parameter int IDW   = 4,
   parameter int CNT_W = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           accept,
   input  logic           merge,
   input  logic           nonzero,
   input  logic           dec,
   input  logic [IDW-1:0] dec_id,
   input  logic [IDW-1:0] query_id,
   output logic [IDW-1:0] assign_id,
   output logic           query_done
);
   localparam int NID = 1 << IDW;

   logic [IDW-1:0]   next_id, last_id;
   logic [CNT_W-1:0] cnt [NID];

   assign assign_id  = merge ? last_id : next_id;
   assign query_done = (cnt[query_id] == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_id <= '0;
         last_id <= '0;
      end else if (accept) begin
         last_id <= assign_id;
         if (!merge) next_id <= next_id + 1'b1;
      end
   end

   for (genvar i = 0; i < NID; i++) begin : g_cnt
      logic inc_i, dec_i;
      assign inc_i = accept && nonzero && (assign_id == IDW'(i));
      assign dec_i = dec && (dec_id == IDW'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) cnt[i] <= '0;
         else        cnt[i] <= cnt[i] + CNT_W'(inc_i) - CNT_W'(dec_i);
      end

      a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
         dec_i |-> (cnt[i] != '0));
      a_r5_no_saturate: assert property (@(posedge clk) disable iff (!rst_n)
         (inc_i && !dec_i) |-> (cnt[i] != '1));
   end
endmodule

// File: rtl/tile_dma.sv
module tile_dma #(
   parameter int AW    = 10,
   parameter int DW    = 32,
   parameter int LW    = 8,
   parameter int IDW   = 4,
   parameter int DEPTH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid,
   output logic           cmd_ready,
   input  logic           cmd_2d,
   input  logic           cmd_merge,
   input  logic [AW-1:0]  cmd_src,
   input  logic [AW-1:0]  cmd_dst,
   input  logic [LW-1:0]  cmd_len,
   input  logic [LW-1:0]  cmd_line,
   input  logic [AW-1:0]  cmd_stride,
   output logic [IDW-1:0] cmd_id,
   input  logic [IDW-1:0] wait_id,
   output logic           wait_done,
   output logic           src_rd_en,
   output logic [AW-1:0]  src_addr,
   input  logic [DW-1:0]  src_rdata,
   output logic           dst_wr_en,
   output logic [AW-1:0]  dst_addr,
   output logic [DW-1:0]  dst_wdata
);
   localparam int CMD_W = 1 + 3*AW - AW + 2*LW + AW + IDW;
   localparam int CNT_W = $clog2(DEPTH + 2) + 1;

   if (IDW < 2 || (1 << IDW) <= DEPTH + 1) begin : g_bad_idw
      $error("tile_dma: ticket space must exceed the commands in flight");
   end

   logic             full, empty, pop, accept;
   logic [CMD_W-1:0] q_in, q_out;
   logic             q_2d;
   logic [AW-1:0]    q_src, q_dst, q_stride;
   logic [LW-1:0]    q_len, q_line;
   logic [IDW-1:0]   q_id;
   logic             g_last;
   logic [AW-1:0]    g_dst;
   logic [IDW-1:0]   g_id;
   logic             wr_last_q;
   logic [IDW-1:0]   wr_id_q;

   assign cmd_ready = !full;
   assign accept    = cmd_valid && cmd_ready;
   assign q_in      = {cmd_2d, cmd_src, cmd_dst, cmd_len, cmd_line, cmd_stride, cmd_id};
   assign {q_2d, q_src, q_dst, q_len, q_line, q_stride, q_id} = q_out;

   tdma_id_track #(.IDW(IDW), .CNT_W(CNT_W)) u_ids (
      .clk, .rst_n,
      .accept     (accept),
      .merge      (cmd_merge),
      .nonzero    (cmd_len != '0),
      .dec        (dst_wr_en && wr_last_q),
      .dec_id     (wr_id_q),
      .query_id   (wait_id),
      .assign_id  (cmd_id),
      .query_done (wait_done)
   );

   tdma_cmd_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_q (
      .clk, .rst_n,
      .push  (accept),
      .din   (q_in),
      .full  (full),
      .pop   (pop),
      .dout  (q_out),
      .empty (empty)
   );

   tdma_addr_gen #(.AW(AW), .LW(LW), .IDW(IDW)) u_gen (
      .clk, .rst_n,
      .cmd_avail (!empty),
      .c_2d      (q_2d),
      .c_src     (q_src),
      .c_dst     (q_dst),
      .c_len     (q_len),
      .c_line    (q_line),
      .c_stride  (q_stride),
      .c_id      (q_id),
      .pop       (pop),
      .rd_en     (src_rd_en),
      .rd_addr   (src_addr),
      .out_dst   (g_dst),
      .out_last  (g_last),
      .out_id    (g_id)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_wr_en <= 1'b0;
         dst_addr  <= '0;
         wr_last_q <= 1'b0;
         wr_id_q   <= '0;
      end else begin
         dst_wr_en <= src_rd_en;
         dst_addr  <= g_dst;
         wr_last_q <= src_rd_en && g_last;
         wr_id_q   <= g_id;
      end
   end

   assign dst_wdata = src_rdata;

   a_r6_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      src_rd_en |=> dst_wr_en);
   a_r6_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      !src_rd_en |=> !dst_wr_en);
   a_r2_dst_linear: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_wr_en && $past(dst_wr_en) && !$past(wr_last_q)) |->
         (dst_addr == $past(dst_addr) + 1'b1));
   a_r8_empty_cmd_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && q_len == '0 && !src_rd_en) |=> !src_rd_en);
endmodule

// File: tb/tb_tile_dma.sv
module tb_tile_dma;
   localparam int AW = 10, DW = 32, LW = 8, IDW = 4;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           cmd_valid, cmd_ready, cmd_2d, cmd_merge;
   logic [AW-1:0]  cmd_src, cmd_dst, cmd_stride;
   logic [LW-1:0]  cmd_len, cmd_line;
   logic [IDW-1:0] cmd_id, wait_id;
   logic           wait_done;
   logic           src_rd_en, dst_wr_en;
   logic [AW-1:0]  src_addr, dst_addr;
   logic [DW-1:0]  src_rdata, dst_wdata;

   int total = 0, bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   tile_dma dut (.*);

   function automatic logic [DW-1:0] home_val(input int a);
      return DW'(a * 32'h9E37 + 32'h5A5);
   endfunction

   logic [DW-1:0] scratch [1 << AW];

   always @(posedge clk) begin
      if (src_rd_en) src_rdata <= home_val(int'(src_addr));
      if (dst_wr_en) scratch[dst_addr] <= dst_wdata;
   end

   // R6 monitor: each write matches the read of the previous cycle
   int r6_bad = 0, r6_seen = 0;
   logic          prev_rd = 1'b0;
   logic [AW-1:0] prev_addr = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_rd) begin
            r6_seen++;
            if (!dst_wr_en || dst_wdata != home_val(int'(prev_addr))) r6_bad++;
         end else if (dst_wr_en) r6_bad++;
         prev_rd   = src_rd_en;
         prev_addr = src_addr;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic d2, input logic mg, input int s, input int d,
                       input int l, input int ln, input int st,
                       output logic acc, output logic [IDW-1:0] id);
      @(negedge clk);
      cmd_valid  = 1'b1;
      cmd_2d     = d2;
      cmd_merge  = mg;
      cmd_src    = AW'(s);
      cmd_dst    = AW'(d);
      cmd_len    = LW'(l);
      cmd_line   = LW'(ln);
      cmd_stride = AW'(st);
      #1;
      acc = cmd_ready;
      id  = cmd_id;
   endtask

   task automatic drop();
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_ticket(input logic [IDW-1:0] t, output logic ok);
      wait_id = t;
      ok = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (wait_done) begin ok = 1'b1; break; end
      end
   endtask

   function automatic int region_errors(input logic d2, input int s, input int d,
                                        input int l, input int ln, input int st);
      int e = 0;
      int row = (d2 && ln != 0) ? ln : l;
      for (int k = 0; k < l; k++) begin
         int sa = s + (k / row) * st + (k % row);
         if (scratch[AW'(d + k)] !== home_val(sa)) e++;
      end
      return e;
   endfunction

   // {tile, src, dst, len, row, pitch}
   localparam int VW = 1 + AW + AW + LW + LW + AW;
   localparam logic [VW-1:0] VEC [8] = '{
      {1'b0, 10'd10,  10'd0,   8'd8,  8'd0, 10'd0},   // R1 linear
      {1'b0, 10'd100, 10'd16,  8'd1,  8'd0, 10'd0},   // R1 single word
      {1'b1, 10'd200, 10'd32,  8'd12, 8'd4, 10'd10},  // R2 full rows
      {1'b1, 10'd300, 10'd48,  8'd10, 8'd3, 10'd7},   // R2 short last row
      {1'b1, 10'd400, 10'd64,  8'd5,  8'd0, 10'd9},   // R2 row width 0
      {1'b1, 10'd500, 10'd80,  8'd6,  8'd1, 10'd20},  // R2 one-word rows
      {1'b1, 10'd600, 10'd96,  8'd9,  8'd3, 10'd3},   // R2 pitch = row
      {1'b0, 10'd900, 10'd112, 8'd30, 8'd0, 10'd0}    // R1 long linear
   };

   initial begin
      logic acc, ok;
      logic [IDW-1:0] id, mid;
      logic [IDW-1:0] ids [6];
      logic accs [6];
      int n_acc;
      cmd_valid = 0; cmd_2d = 0; cmd_merge = 0;
      cmd_src = '0; cmd_dst = '0; cmd_len = '0; cmd_line = '0; cmd_stride = '0;
      wait_id = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      check("R9 ready", 64'(cmd_ready), 64'd1);
      check("R9 no read", 64'(src_rd_en), 64'd0);
      check("R9 no write", 64'(dst_wr_en), 64'd0);
      begin
         int nd = 0;
         for (int t = 0; t < 16; t++) begin wait_id = IDW'(t); #1; if (wait_done) nd++; end
         check("R9 all tickets done", 64'(nd), 64'd16);
      end

      // table-driven copies, R1 R2 R3
      for (int v = 0; v < 8; v++) begin
         logic d2; int s, d, l, ln, st;
         {d2, s, d, l, ln, st} = {VEC[v][VW-1], 22'd0, VEC[v][VW-2 -: AW],
                                  22'd0, VEC[v][VW-2-AW -: AW], 24'd0, VEC[v][VW-2-2*AW -: LW],
                                  24'd0, VEC[v][AW+LW-1 -: LW], 22'd0, VEC[v][AW-1:0]};
         send(d2, 1'b0, s, d, l, ln, st, acc, id);
         drop();
         check("R3 ticket sequence", 64'(id), 64'(v));
         #1 wait_id = id; #1;
         check("R5 pending after accept", 64'(wait_done), 64'd0);
         wait_ticket(id, ok);
         check(d2 ? "R2 tile data" : "R1 linear data",
               64'(ok ? region_errors(d2, s, d, l, ln, st) : 999), 64'd0);
      end

      // R8 zero-length command: ticket 8 used, no access
      send(1'b0, 1'b0, 5, 200, 0, 0, 0, acc, id);
      drop();
      check("R8 zero-length ticket", 64'(id), 64'd8);
      wait_id = id; #1;
      check("R8 zero-length done", 64'(wait_done), 64'd1);
      begin
         int rds = 0;
         for (int i = 0; i < 4; i++) begin @(negedge clk); if (src_rd_en) rds++; end
         check("R8 no access", 64'(rds), 64'd0);
      end

      // R4 R5 R10 join: long copy then joined short copy
      send(1'b0, 1'b0, 0, 200, 40, 0, 0, acc, id);
      send(1'b0, 1'b1, 50, 300, 4, 0, 0, acc, mid);
      check("R10 accept while copying", 64'(acc), 64'd1);
      drop();
      check("R3 ticket after empty command", 64'(id), 64'd9);
      check("R4 joined ticket", 64'(mid), 64'(id));
      wait_id = id;
      repeat (30) @(negedge clk);
      check("R5 joined still pending", 64'(wait_done), 64'd0);
      wait_ticket(id, ok);
      check("R5 all joined copies written", 64'(ok ? region_errors(0, 0, 200, 40, 0, 0)
            + region_errors(0, 50, 300, 4, 0, 0) : 999), 64'd0);

      // R7 queue full: six back-to-back commands
      n_acc = 0;
      for (int i = 0; i < 6; i++) begin
         send(1'b0, 1'b0, 10 * i, 400 + 40 * i, 40, 0, 0, acc, id);
         accs[i] = acc; ids[i] = id;
         if (acc) n_acc++;
      end
      drop();
      check("R7 accepted before full", 64'(n_acc), 64'd5);
      check("R7 sixth refused", 64'(accs[5]), 64'd0);
      check("R7 ticket of fifth", 64'(ids[4]), 64'd14);
      wait_ticket(ids[4], ok);
      begin
         int e = 0;
         for (int i = 0; i < 5; i++) e += region_errors(0, 10 * i, 400 + 40 * i, 40, 0, 0);
         check("R7 queued copies intact", 64'(ok ? e : 999), 64'd0);
      end
      send(1'b0, 1'b0, 0, 0, 0, 0, 0, acc, id);
      drop();
      check("R7 refused command not ticketed", 64'(id), 64'd15);

      repeat (3) @(negedge clk);
      check("R6 writes follow reads", 64'(r6_bad), 64'd0);
      check("R6 reads observed", 64'(r6_seen > 100), 64'd1);

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule